// File: doc/BRIEF.md
# Clocked Serial Link Device with Channel Select

This block is the device end of a half-duplex synchronous serial link. The bit clock is owned by an external master and reaches the block as a single-cycle strobe, `sclk_rise`, already synchronised into the system clock domain. Each strobe is one rising edge of the serial clock. On that edge the block samples `sdi` and updates `sdo`. Between strobes nothing advances, so the master may stop its clock partway through a frame and the block keeps its bit position.

Frames in both directions have the same layout. A 0 start bit comes first, then the data byte least significant bit first, then a destination bit. On receive, the destination bit picks channel A (0) or channel B (1). If the chosen channel is not enabled, the byte falls back to the other channel. The byte is presented on `rx_data` with a one-cycle pulse on that channel's valid output. Clear-to-send (`cts`) drops when a start bit is seen and rises again once the consumer raises `rx_ready`.

On transmit, the block sends the byte held on `tx_data`. The destination bit it sends names the source channel after the same fallback. If the master starts a frame on the same edge the block starts its own, the block drops its transmission and receives the incoming frame. Its byte stays pending and is sent again later.

Receive state machine states:
- `RX_IDLE`: waits for a start bit.
- `RX_DATA`: shifts in the data bits.
- `RX_DEST`: samples the destination bit.
- `RX_HOLD`: waits for the consumer.

Receive transitions:
- `RX_IDLE` goes to `RX_DATA` on a 0 sample.
- `RX_DATA` goes to `RX_DEST` after the last data bit.
- `RX_DEST` goes to `RX_HOLD` on the next strobe, which delivers the byte.
- `RX_HOLD` goes to `RX_IDLE` on `rx_ready`.

Transmit state machine states:
- `TX_IDLE`: waits for a pending byte.
- `TX_START`: the start bit is on the line.
- `TX_DATA`: data bits are on the line.
- `TX_DEST`: the destination bit is on the line.

Transmit transitions:
- `TX_IDLE` goes to `TX_START` at launch.
- `TX_START` goes back to `TX_IDLE` on contention (back-off), otherwise to `TX_DATA`.
- `TX_DATA` goes to `TX_DEST` after D7.
- `TX_DEST` goes to `TX_IDLE` with a done pulse.

When no channel is enabled, both machines are forced to their idle states.

Top module: `clkser_link`

## Requirements
- R1: After reset, `sdo` is 1, `rx_valid_a`, `rx_valid_b` and `tx_done` are 0, and `cts` is 1 when at least one channel is enabled.
- R2: A received frame is a 0 start bit, then eight data bits with bit 0 first, then the destination bit. `rx_data` equals the assembled byte in the cycle its valid pulse is high.
- R3: `cts` goes low in the system cycle after a strobe that samples `sdi`=0 while `cts` is high. It stays low until `rx_ready` is seen high after the byte has been delivered.
- R4: A destination bit of 0 delivers on channel A when `en_a`=1, and on channel B when `en_a`=0.
- R5: A destination bit of 1 delivers on channel B when `en_b`=1, and on channel A when `en_b`=0.
- R6: With `en_a`=`en_b`=0, `cts` is 0, no frame is received, and `sdo` stays 1 even with `tx_valid` high.
- R7: A transmitted frame drives these values on `sdo`, each in the cycle after a strobe:
  - 0 after the launch strobe;
  - D0..D7 after the next eight strobes;
  - the destination bit after the following strobe, equal to 1 for channel B after fallback (`tx_chan`=1 selects B);
  - 1 after the last strobe, together with a one-cycle `tx_done` pulse.
- R8: If `sdi` is sampled 0 while the start bit is on `sdo`, `sdo` returns to 1, `tx_done` does not pulse, and the incoming frame is received. The unchanged pending byte is then sent in full later.
- R9: Without strobes, `sdo` holds its value and no frame progresses.
- R10: Each received frame gives exactly one one-cycle valid pulse, on one channel port only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_a | input | 1 | Channel A enabled for the link |
| en_b | input | 1 | Channel B enabled for the link |
| sclk_rise | input | 1 | One-cycle strobe per serial clock rising edge |
| sdi | input | 1 | Serial data in, idle high |
| sdo | output | 1 | Serial data out, idle high |
| cts | output | 1 | Clear-to-send towards the master |
| rx_data | output | 8 | Last received byte |
| rx_valid_a | output | 1 | Byte delivered to channel A |
| rx_valid_b | output | 1 | Byte delivered to channel B |
| rx_ready | input | 1 | Consumer can take another byte |
| tx_valid | input | 1 | A byte is pending; hold until `tx_done` |
| tx_data | input | 8 | Pending byte |
| tx_chan | input | 1 | Source channel of the pending byte (1 = B) |
| tx_done | output | 1 | Pending byte fully sent |

## Verification
The assertions assume the following about the inputs:
- `sclk_rise` is a clean single-cycle strobe.
- `en_a` and `en_b` stay constant while a frame is on the line.
- `tx_valid`, `tx_data` and `tx_chan` stay unchanged from launch until `tx_done`.

The stimulus drives every strobe as an isolated one-cycle pulse at a falling clock edge, followed by a random number of idle cycles. Channel enables change only between frames, and transmit inputs are released only after the done pulse. The contention case is built deliberately by holding `sdi` at 0 on the strobe that follows the device's launch.

// File: rtl/clkser_pkg.sv
package clkser_pkg;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_DATA,
        RX_DEST,
        RX_HOLD
    } rx_state_e;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_DEST
    } tx_state_e;

endpackage

// File: rtl/clkser_route.sv
// Resolves the requested channel against the enables: 1 = channel B.
module clkser_route (
    input  logic dest,
    input  logic en_a,
    input  logic en_b,
    output logic to_b
);
    always_comb begin
        if (dest) begin
            to_b = en_b;
        end else begin
            to_b = ~en_a;
        end
    end
endmodule

// File: rtl/clkser_rx.sv
module clkser_rx
    import clkser_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_en,
    input  logic              bit_tick,
    input  logic              sdi,
    input  logic              tx_busy,
    input  logic              en_a,
    input  logic              en_b,
    input  logic              rx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid_a,
    output logic              rx_valid_b,
    output logic              rx_idle
);
    localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    rx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] shift_q;
    logic              to_b;

    clkser_route u_route (
        .dest (sdi),
        .en_a (en_a),
        .en_b (en_b),
        .to_b (to_b)
    );

    always_comb begin
        state_d = state_q;
        if (!link_en) begin
            state_d = RX_IDLE;
        end else begin
            unique case (state_q)
                RX_IDLE: if (bit_tick && !sdi && !tx_busy) state_d = RX_DATA;
                RX_DATA: if (bit_tick && cnt_q == LAST_BIT) state_d = RX_DEST;
                RX_DEST: if (bit_tick) state_d = RX_HOLD;
                RX_HOLD: if (rx_ready) state_d = RX_IDLE;
                default: state_d = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            shift_q    <= '0;
            rx_data    <= '0;
            rx_valid_a <= 1'b0;
            rx_valid_b <= 1'b0;
        end else begin
            rx_valid_a <= 1'b0;
            rx_valid_b <= 1'b0;
            if (link_en && bit_tick) begin
                unique case (state_q)
                    RX_IDLE: cnt_q <= '0;
                    RX_DATA: begin
                        shift_q <= {sdi, shift_q[DATA_W-1:1]};
                        cnt_q   <= cnt_q + 1'b1;
                    end
                    RX_DEST: begin
                        rx_data    <= shift_q;
                        rx_valid_b <= to_b;
                        rx_valid_a <= ~to_b;
                    end
                    RX_HOLD: cnt_q <= '0;
                    default: cnt_q <= '0;
                endcase
            end
        end
    end

    assign rx_idle = (state_q == RX_IDLE);

endmodule

// File: rtl/clkser_tx.sv
module clkser_tx
    import clkser_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_en,
    input  logic              bit_tick,
    input  logic              sdi,
    input  logic              rx_idle,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_dest,
    output logic              sdo,
    output logic              tx_done,
    output logic              tx_busy,
    output logic              tx_idle
);
    localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    tx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] shift_q;
    logic              dest_q;
    logic              launch;

    // Launch only on a high sample: a low sample on the same edge belongs to the receiver.
    assign launch = bit_tick && link_en && rx_idle && tx_valid && sdi && (state_q == TX_IDLE);

    always_comb begin
        state_d = state_q;
        if (!link_en) begin
            state_d = TX_IDLE;
        end else begin
            unique case (state_q)
                TX_IDLE:  if (launch) state_d = TX_START;
                TX_START: if (bit_tick) state_d = sdi ? TX_DATA : TX_IDLE;
                TX_DATA:  if (bit_tick && cnt_q == LAST_BIT) state_d = TX_DEST;
                TX_DEST:  if (bit_tick) state_d = TX_IDLE;
                default:  state_d = TX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo     <= 1'b1;
            tx_done <= 1'b0;
            cnt_q   <= '0;
            shift_q <= '0;
            dest_q  <= 1'b0;
        end else begin
            tx_done <= 1'b0;
            if (!link_en) begin
                sdo <= 1'b1;
            end else if (bit_tick) begin
                unique case (state_q)
                    TX_IDLE: begin
                        if (launch) begin
                            sdo     <= 1'b0;
                            shift_q <= tx_data;
                            dest_q  <= tx_dest;
                        end
                    end
                    TX_START: begin
                        if (!sdi) begin
                            sdo <= 1'b1;
                        end else begin
                            sdo     <= shift_q[0];
                            shift_q <= shift_q >> 1;
                            cnt_q   <= '0;
                        end
                    end
                    TX_DATA: begin
                        if (cnt_q == LAST_BIT) begin
                            sdo <= dest_q;
                        end else begin
                            sdo     <= shift_q[0];
                            shift_q <= shift_q >> 1;
                        end
                        cnt_q <= cnt_q + 1'b1;
                    end
                    TX_DEST: begin
                        sdo     <= 1'b1;
                        tx_done <= 1'b1;
                    end
                    default: sdo <= 1'b1;
                endcase
            end
        end
    end

    assign tx_busy = (state_q == TX_DATA) || (state_q == TX_DEST);
    assign tx_idle = (state_q == TX_IDLE);

endmodule

// File: rtl/clkser_link.sv
module clkser_link #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_a,
    input  logic              en_b,
    input  logic              sclk_rise,
    input  logic              sdi,
    output logic              sdo,
    output logic              cts,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid_a,
    output logic              rx_valid_b,
    input  logic              rx_ready,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_chan,
    output logic              tx_done
);
    logic link_en;
    logic rx_idle;
    logic tx_busy;
    logic tx_idle;
    logic tx_dest;

    assign link_en = en_a | en_b;

    clkser_route u_tx_route (
        .dest (tx_chan),
        .en_a (en_a),
        .en_b (en_b),
        .to_b (tx_dest)
    );

    clkser_rx #(.DATA_W(DATA_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_en    (link_en),
        .bit_tick   (sclk_rise),
        .sdi        (sdi),
        .tx_busy    (tx_busy),
        .en_a       (en_a),
        .en_b       (en_b),
        .rx_ready   (rx_ready),
        .rx_data    (rx_data),
        .rx_valid_a (rx_valid_a),
        .rx_valid_b (rx_valid_b),
        .rx_idle    (rx_idle)
    );

    clkser_tx #(.DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .link_en  (link_en),
        .bit_tick (sclk_rise),
        .sdi      (sdi),
        .rx_idle  (rx_idle),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_dest  (tx_dest),
        .sdo      (sdo),
        .tx_done  (tx_done),
        .tx_busy  (tx_busy),
        .tx_idle  (tx_idle)
    );

    assign cts = link_en & rx_idle & tx_idle;

endmodule

// File: rtl/clkser_link_chk.sv
module clkser_link_chk (
    input logic clk,
    input logic rst_n,
    input logic en_a,
    input logic en_b,
    input logic sclk_rise,
    input logic sdi,
    input logic sdo,
    input logic cts,
    input logic rx_valid_a,
    input logic rx_valid_b,
    input logic tx_done
);
    assert_cts_off_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_a && !en_b) |-> !cts);

    assert_cts_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cts && sclk_rise && !sdi) |=> !cts);

    assert_one_port_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_valid_a, rx_valid_b}));

    assert_valid_a_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_a |=> !rx_valid_a);

    assert_valid_b_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_b |=> !rx_valid_b);

    assert_sdo_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_rise && (en_a || en_b)) |=> $stable(sdo));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);
endmodule

bind clkser_link clkser_link_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_a       (en_a),
    .en_b       (en_b),
    .sclk_rise  (sclk_rise),
    .sdi        (sdi),
    .sdo        (sdo),
    .cts        (cts),
    .rx_valid_a (rx_valid_a),
    .rx_valid_b (rx_valid_b),
    .tx_done    (tx_done)
);

// File: tb/clkser_link_test.sv
`timescale 1ns/1ps
module clkser_link_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_a = 1'b1, en_b = 1'b1;
    logic       sclk_rise = 1'b0, sdi = 1'b1;
    logic       sdo, cts, rx_valid_a, rx_valid_b, tx_done;
    logic [7:0] rx_data;
    logic       rx_ready = 1'b1;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_chan = 1'b0;

    int n_checks = 0, n_fail = 0;
    int vcount = 0, dcount = 0, cycles = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    clkser_link uut (
        .clk(clk), .rst_n(rst_n), .en_a(en_a), .en_b(en_b),
        .sclk_rise(sclk_rise), .sdi(sdi), .sdo(sdo), .cts(cts),
        .rx_data(rx_data), .rx_valid_a(rx_valid_a), .rx_valid_b(rx_valid_b),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_chan(tx_chan), .tx_done(tx_done)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rx_valid_a || rx_valid_b) vcount <= vcount + 1;
        if (tx_done) dcount <= dcount + 1;
    end

    always @(posedge clk) begin
        if (cycles > 150000 && !finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    function automatic bit exp_to_b(input bit dest, input bit ea, input bit eb);
        return dest ? eb : !ea;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One strobe; returns at the falling edge right after the sampling edge.
    task automatic strobe(input bit d);
        @(negedge clk);
        sdi = d;
        sclk_rise = 1'b1;
        @(negedge clk);
        sclk_rise = 1'b0;
    endtask

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rx_frame(input logic [7:0] b, input bit dest, input bit stall);
        int v0;
        bit tb;
        v0 = vcount;
        strobe(1'b0);
        check(cts == 1'b0, "R3 cts low after start", cts, 0);
        for (int i = 0; i < 8; i++) begin
            strobe(b[i]);
            if (stall) gap($urandom_range(0, 4));
        end
        strobe(dest);
        sdi = 1'b1;
        tb = exp_to_b(dest, en_a, en_b);
        check(rx_data == b, "R2 received byte", rx_data, b);
        check(rx_valid_b == tb && rx_valid_a == !tb,
              dest ? "R5 route dest1" : "R4 route dest0",
              {rx_valid_a, rx_valid_b}, {!tb, tb});
        @(negedge clk);
        check(vcount == v0 + 1, "R10 one pulse per frame", vcount - v0, 1);
    endtask

    task automatic tx_frame(input logic [7:0] b, input bit ch, input bit stall);
        bit db;
        int d0;
        d0 = dcount;
        db = exp_to_b(ch, en_a, en_b);
        tx_data = b; tx_chan = ch; tx_valid = 1'b1;
        strobe(1'b1);
        check(sdo == 1'b0, "R7 start bit", sdo, 0);
        for (int i = 0; i < 8; i++) begin
            strobe(1'b1);
            check(sdo == b[i], "R7 data bit", sdo, b[i]);
            if (stall) begin
                gap(3);
                check(sdo == b[i], "R9 sdo holds while clock stalled", sdo, b[i]);
            end
        end
        strobe(1'b1);
        check(sdo == db, "R7 destination bit", sdo, db);
        strobe(1'b1);
        check(sdo == 1'b1 && tx_done == 1'b1, "R7 idle and done", {sdo, tx_done}, 2'b11);
        tx_valid = 1'b0;
        @(negedge clk);
        check(dcount == d0 + 1, "R7 single done pulse", dcount - d0, 1);
    endtask

    initial begin
        int v0, d0;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(sdo == 1'b1 && !rx_valid_a && !rx_valid_b && !tx_done && cts,
              "R1 reset state", {sdo, rx_valid_a, rx_valid_b, tx_done, cts}, 5'b10001);

        // Directed routing corners
        en_a = 1; en_b = 1; rx_frame(8'hA5, 0, 0);
        en_a = 1; en_b = 1; rx_frame(8'h3C, 1, 0);
        en_a = 0; en_b = 1; rx_frame(8'h01, 0, 0);
        en_a = 1; en_b = 0; rx_frame(8'h80, 1, 0);
        en_a = 1; en_b = 1;

        // R3: cts held low until rx_ready
        rx_ready = 1'b0;
        rx_frame(8'h5A, 0, 0);
        gap(5);
        check(cts == 1'b0, "R3 cts low while consumer busy", cts, 0);
        rx_ready = 1'b1;
        gap(2);
        check(cts == 1'b1, "R3 cts back after ready", cts, 1);

        // R6: disabled link
        en_a = 0; en_b = 0;
        @(negedge clk);
        check(cts == 1'b0, "R6 cts low when disabled", cts, 0);
        v0 = vcount;
        strobe(0);
        for (int i = 0; i < 9; i++) strobe(i[0]);
        sdi = 1'b1;
        gap(2);
        check(vcount == v0, "R6 nothing received when disabled", vcount - v0, 0);
        tx_data = 8'h55; tx_valid = 1'b1;
        for (int i = 0; i < 4; i++) begin
            strobe(1);
            check(sdo == 1'b1, "R6 sdo idle when disabled", sdo, 1);
        end
        tx_valid = 1'b0;
        en_a = 1; en_b = 1;
        gap(2);

        // Directed transmit, with stalls
        tx_frame(8'hC3, 1, 1);
        en_a = 1; en_b = 0; gap(1);
        tx_frame(8'h96, 1, 0);
        en_a = 1; en_b = 1; gap(1);

        // R8: contention, device backs off
        d0 = dcount;
        tx_data = 8'hE7; tx_chan = 0; tx_valid = 1'b1;
        strobe(1);
        check(sdo == 1'b0, "R8 device start bit out", sdo, 0);
        v0 = vcount;
        strobe(0);
        check(sdo == 1'b1 && cts == 1'b0, "R8 back-off releases line", {sdo, cts}, 2'b10);
        for (int i = 0; i < 8; i++) strobe(8'h4D >> i);
        strobe(1);
        check(rx_data == 8'h4D && rx_valid_b, "R8 incoming frame received", rx_data, 8'h4D);
        @(negedge clk);
        check(dcount == d0 && vcount == v0 + 1, "R8 no done after back-off", dcount - d0, 0);
        tx_valid = 1'b0;
        gap(2);
        tx_frame(8'hE7, 0, 0);

        // Random mix
        for (int n = 0; n < 40; n++) begin
            logic [7:0] b;
            bit dir, ch;
            int e;
            b = 8'($urandom);
            dir = 1'($urandom);
            ch = 1'($urandom);
            e = $urandom_range(1, 3);
            en_a = e[0]; en_b = e[1];
            gap($urandom_range(1, 3));
            if (dir) rx_frame(b, ch, 1);
            else tx_frame(b, ch, $urandom_range(0, 1) == 1);
        end

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule